// File: doc/BRIEF.md
# Programmable Sum-of-Products Core with Term Steering

This block is the logic core of one cell group in a programmable sum-of-products device. Thirty-six routed signals enter. Each one is offered in true form and in inverted form, which gives 72 literals. Eighty-six AND terms each pick any subset of those literals. A steering stage then gathers, for each of sixteen outputs, the OR of whichever terms are routed to it. The sixteen sums go on to downstream storage cells.

The terms are not tied to particular outputs. Any output may take from zero to sixteen terms, and one term may drive several outputs at the same time, so logic that outputs share is built only once. Configuration is loaded through a plain write port. Each write carries one AND-row literal mask or one output steering mask and takes effect on the next clock edge. A steering mask that would give an output more than sixteen terms is refused.

Top module: `pta_core`

## Requirements
- R1: Literal 2*i is input i and literal 2*i+1 is its inverse. A term is 1 exactly when every literal selected in its row mask (bit k selects literal k) is 1.
- R2: A term whose row mask is empty evaluates to 1. A term whose mask selects both forms of the same input evaluates to 0.
- R3: Output o is the OR of all terms t whose bit t is set in the steering mask of output o. An output with an empty mask is 0.
- R4: One term set in several steering masks drives all of those outputs at once.
- R5: A steering mask with exactly 16 bits set is accepted and acts like any other mask.
- R6: A steering write with more than 16 bits set leaves that output's previous mask in place. It raises cfg_err_o for exactly the one cycle after the refusing clock edge.
- R7: With cfg_we_i high, cfg_kind_i=0 writes cfg_data_i[71:0] to AND row cfg_addr_i, and cfg_kind_i=1 writes cfg_data_i[85:0] as the steering mask of output cfg_addr_i. The outputs change only after that clock edge.
- R8: A write whose address is out of range (row 86 or above, output 16 or above) changes nothing and raises no error.
- R9: After reset, all row masks and steering masks are empty, every sum is 0 and cfg_err_o is 0.
- R10: The sums respond to a change on in_i in the same cycle, with no clock edge needed.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock for the configuration store |
| rst_n | input | 1 | Asynchronous active-low reset |
| in_i | input | 36 | Routed input signals |
| cfg_we_i | input | 1 | Configuration write strobe |
| cfg_kind_i | input | 1 | Write target: 0 selects an AND row, 1 selects a steering mask |
| cfg_addr_i | input | 7 | Row index or output index |
| cfg_data_i | input | 86 | Mask data to write |
| sum_o | output | 16 | Sum-of-products outputs |
| cfg_err_o | output | 1 | One-cycle flag that a steering mask was refused |

## Verification
The assertions check, on every cycle, the rules that govern the configuration store. No stored steering mask ever holds more than 16 terms. An output with an empty mask stays low. A refused or out-of-range steering write leaves every mask unchanged. The error flag appears only after an over-full steering write. A valid row write lands in the addressed row.

Only the bench's scenarios can show the logic function itself. They cover literal polarity, the value of an empty term and of a contradictory term, sharing of one term among several outputs, same-cycle response to the inputs, and the fact that the previous mask still drives its output after a refused write.

// File: rtl/pta_pkg.sv
package pta_pkg;
    parameter int unsigned N_IN      = 36;
    parameter int unsigned N_TERM    = 86;
    parameter int unsigned N_OUT     = 16;
    parameter int unsigned MAX_TERMS = 16;

    localparam int unsigned LIT_W     = 2 * N_IN;
    localparam int unsigned ADDR_W    = $clog2((N_TERM > N_OUT) ? N_TERM : N_OUT);
    localparam int unsigned OUT_IDX_W = $clog2(N_OUT);
    localparam int unsigned DATA_W    = (LIT_W > N_TERM) ? LIT_W : N_TERM;
    localparam int unsigned CNT_W     = $clog2(N_TERM + 1);

    typedef logic [LIT_W-1:0]  lit_row_t;
    typedef logic [N_TERM-1:0] steer_row_t;

    typedef enum logic {
        CFG_AND   = 1'b0,
        CFG_STEER = 1'b1
    } cfg_kind_e;

    typedef struct packed {
        lit_row_t   [N_TERM-1:0] and_rows;
        steer_row_t [N_OUT-1:0]  steer;
        logic                    err;
    } cfg_state_t;
endpackage

// File: rtl/pta_literals.sv
module pta_literals
    import pta_pkg::*;
(
    input  logic [N_IN-1:0] in_i,
    output lit_row_t        lit_o
);
    for (genvar i = 0; i < N_IN; i++) begin : g_lit
        assign lit_o[2*i]   = in_i[i];
        assign lit_o[2*i+1] = ~in_i[i];
    end
endmodule

// File: rtl/pta_and_plane.sv
module pta_and_plane
    import pta_pkg::*;
(
    input  lit_row_t                lit_i,
    input  lit_row_t [N_TERM-1:0]   rows_i,
    output logic     [N_TERM-1:0]   term_o
);
    // a literal that is not selected counts as true
    for (genvar t = 0; t < N_TERM; t++) begin : g_term
        assign term_o[t] = &(~rows_i[t] | lit_i);
    end
endmodule

// File: rtl/pta_or_plane.sv
module pta_or_plane
    import pta_pkg::*;
(
    input  logic       [N_TERM-1:0] term_i,
    input  steer_row_t [N_OUT-1:0]  steer_i,
    output logic       [N_OUT-1:0]  sum_o
);
    for (genvar o = 0; o < N_OUT; o++) begin : g_sum
        assign sum_o[o] = |(steer_i[o] & term_i);
    end
endmodule

// File: rtl/pta_popcnt.sv
module pta_popcnt #(
    parameter int unsigned W   = 86,
    parameter int unsigned C_W = $clog2(W + 1)
) (
    input  logic [W-1:0]   vec_i,
    output logic [C_W-1:0] cnt_o
);
    always_comb begin
        cnt_o = '0;
        for (int k = 0; k < W; k++) begin
            cnt_o = cnt_o + C_W'(vec_i[k]);
        end
    end
endmodule

// File: rtl/pta_core.sv
module pta_core
    import pta_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic [N_IN-1:0]   in_i,
    input  logic              cfg_we_i,
    input  logic              cfg_kind_i,
    input  logic [ADDR_W-1:0] cfg_addr_i,
    input  logic [DATA_W-1:0] cfg_data_i,
    output logic [N_OUT-1:0]  sum_o,
    output logic              cfg_err_o
);
    cfg_state_t st_d, st_q;

    lit_row_t            lits;
    logic [N_TERM-1:0]   terms;
    logic [CNT_W-1:0]    mask_cnt;
    cfg_kind_e           kind;

    assign kind = cfg_kind_e'(cfg_kind_i);

    pta_literals u_lit (
        .in_i  (in_i),
        .lit_o (lits)
    );

    pta_and_plane u_and (
        .lit_i  (lits),
        .rows_i (st_q.and_rows),
        .term_o (terms)
    );

    pta_or_plane u_or (
        .term_i  (terms),
        .steer_i (st_q.steer),
        .sum_o   (sum_o)
    );

    pta_popcnt #(.W(N_TERM), .C_W(CNT_W)) u_cnt (
        .vec_i (cfg_data_i[N_TERM-1:0]),
        .cnt_o (mask_cnt)
    );

    always_comb begin
        st_d     = st_q;
        st_d.err = 1'b0;
        if (cfg_we_i) begin
            if (kind == CFG_AND) begin
                if (cfg_addr_i < ADDR_W'(N_TERM)) begin
                    st_d.and_rows[cfg_addr_i] = cfg_data_i[LIT_W-1:0];
                end
            end else if (cfg_addr_i < ADDR_W'(N_OUT)) begin
                if (mask_cnt > CNT_W'(MAX_TERMS)) begin
                    st_d.err = 1'b1;
                end else begin
                    st_d.steer[cfg_addr_i[OUT_IDX_W-1:0]] = cfg_data_i[N_TERM-1:0];
                end
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign cfg_err_o = st_q.err;
endmodule

// File: rtl/pta_core_chk.sv
module pta_core_chk
    import pta_pkg::*;
(
    input logic              clk,
    input logic              rst_n,
    input logic              cfg_we_i,
    input logic              cfg_kind_i,
    input logic [ADDR_W-1:0] cfg_addr_i,
    input logic [DATA_W-1:0] cfg_data_i,
    input logic [N_OUT-1:0]  sum_o,
    input logic              cfg_err_o,
    input cfg_state_t        st_q
);
    logic steer_wr, bad_steer, and_wr, far_steer;

    assign steer_wr  = cfg_we_i && cfg_kind_i && (cfg_addr_i < ADDR_W'(N_OUT));
    assign bad_steer = steer_wr && ($countones(cfg_data_i[N_TERM-1:0]) > MAX_TERMS);
    assign and_wr    = cfg_we_i && !cfg_kind_i && (cfg_addr_i < ADDR_W'(N_TERM));
    assign far_steer = cfg_we_i && cfg_kind_i && (cfg_addr_i >= ADDR_W'(N_OUT));

    p_err_cause_r6: assert property (@(posedge clk) disable iff (!rst_n)
        cfg_err_o |-> $past(bad_steer));

    p_reject_keeps_r6: assert property (@(posedge clk) disable iff (!rst_n)
        bad_steer |=> $stable(st_q.steer) && cfg_err_o);

    p_row_lands_r7: assert property (@(posedge clk) disable iff (!rst_n)
        and_wr |=> st_q.and_rows[$past(cfg_addr_i)] == $past(cfg_data_i[LIT_W-1:0]));

    p_far_addr_r8: assert property (@(posedge clk) disable iff (!rst_n)
        far_steer |=> $stable(st_q.steer) && !cfg_err_o);

    for (genvar o = 0; o < N_OUT; o++) begin : g_out
        p_cap_r5: assert property (@(posedge clk) disable iff (!rst_n)
            $countones(st_q.steer[o]) <= MAX_TERMS);

        p_empty_low_r3: assert property (@(posedge clk) disable iff (!rst_n)
            (st_q.steer[o] == '0) |-> !sum_o[o]);
    end
endmodule

bind pta_core pta_core_chk i_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .cfg_we_i   (cfg_we_i),
    .cfg_kind_i (cfg_kind_i),
    .cfg_addr_i (cfg_addr_i),
    .cfg_data_i (cfg_data_i),
    .sum_o      (sum_o),
    .cfg_err_o  (cfg_err_o),
    .st_q       (st_q)
);

// File: tb/test_pta_core.sv
`timescale 1ns/100ps
module test_pta_core;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [35:0] in_i = '0;
    logic        cfg_we_i = 1'b0;
    logic        cfg_kind_i = 1'b0;
    logic [6:0]  cfg_addr_i = '0;
    logic [85:0] cfg_data_i = '0;
    logic [15:0] sum_o;
    logic        cfg_err_o;

    int total = 0;
    int bad = 0;
    bit done = 0;

    always #2.5 clk = ~clk;

    pta_core i_pta_core (
        .clk(clk), .rst_n(rst_n), .in_i(in_i), .cfg_we_i(cfg_we_i),
        .cfg_kind_i(cfg_kind_i), .cfg_addr_i(cfg_addr_i), .cfg_data_i(cfg_data_i),
        .sum_o(sum_o), .cfg_err_o(cfg_err_o)
    );

    typedef struct packed {
        logic [35:0] vin;
        logic [15:0] vexp;
    } vec_t;

    // out0=in0&~in1, out1=out0|in2, out2=0, out3=~in35, out4=1, out5=1, out6=out0
    localparam vec_t VECS [6] = '{
        '{36'h0,         16'h0038},
        '{36'h1,         16'h007B},
        '{36'h3,         16'h0038},
        '{36'h4,         16'h003A},
        '{36'h800000001, 16'h0073},
        '{36'hFFFFFFFFF, 16'h0032}
    };

    function automatic logic [85:0] bit_at(int k);
        return 86'(1) << k;
    endfunction

    task automatic check(string req, logic [31:0] act, logic [31:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s: got %h expected %h", req, act, exp);
        end
    endtask

    task automatic wr(logic kind, int addr, logic [85:0] data);
        @(negedge clk);
        cfg_we_i   = 1'b1;
        cfg_kind_i = kind;
        cfg_addr_i = 7'(addr);
        cfg_data_i = data;
        @(posedge clk);
        #1;
        cfg_we_i = 1'b0;
    endtask

    initial begin
        #200000;
        if (!done) begin
            total++;
            bad++;
            $display("FAIL watchdog: got hang expected finish");
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        repeat (3) @(posedge clk);
        #1;
        // R9: reset state
        in_i = 36'hFFFFFFFFF;
        #1;
        check("R9 sums after reset", 32'(sum_o), 32'h0);
        check("R9 err after reset", 32'(cfg_err_o), 32'h0);
        rst_n = 1'b1;

        // R7: setup writes
        wr(1'b0, 0, bit_at(0) | bit_at(3));
        wr(1'b0, 2, bit_at(0) | bit_at(1));
        wr(1'b0, 3, bit_at(4));
        wr(1'b0, 85, bit_at(71));
        wr(1'b1, 0, bit_at(0));
        wr(1'b1, 1, bit_at(0) | bit_at(3));
        wr(1'b1, 2, bit_at(2));
        wr(1'b1, 3, bit_at(85));
        wr(1'b1, 4, bit_at(1));
        wr(1'b1, 5, 86'hFFFF << 4);
        wr(1'b1, 6, bit_at(0));
        check("R5 err after 16-term mask", 32'(cfg_err_o), 32'h0);

        // R1 R2 R3 R4 R10: table walk, inputs change without a clock edge
        foreach (VECS[i]) begin
            @(negedge clk);
            in_i = VECS[i].vin;
            #1;
            check("R1 R2 R3 R4 R10 table", 32'(sum_o), 32'(VECS[i].vexp));
        end

        @(negedge clk);
        in_i = '0;
        #1;
        check("R5 sixteen-term output", 32'(sum_o[5]), 32'h1);
        check("R2 contradictory term", 32'(sum_o[2]), 32'h0);

        // R6: 17-term mask on output 6 (includes always-true term 1)
        wr(1'b1, 6, 86'h1FFFF << 1);
        check("R6 err raised", 32'(cfg_err_o), 32'h1);
        check("R6 previous mask kept", 32'(sum_o[6]), 32'h0);
        @(posedge clk);
        #1;
        check("R6 err one cycle", 32'(cfg_err_o), 32'h0);
        in_i = 36'h1;
        #1;
        check("R6 old mask still drives", 32'(sum_o[6]), 32'h1);

        // R8: output 20 is out of range; would alias to output 4 if truncated
        in_i = '0;
        wr(1'b1, 20, '0);
        check("R8 out4 unchanged", 32'(sum_o[4]), 32'h1);
        check("R8 no err", 32'(cfg_err_o), 32'h0);
        wr(1'b0, 100, bit_at(1));
        check("R8 row write ignored", 32'(sum_o), 32'h0038);

        // R7: output holds until the write's clock edge
        @(negedge clk);
        in_i = 36'h1;
        cfg_we_i   = 1'b1;
        cfg_kind_i = 1'b0;
        cfg_addr_i = 7'd0;
        cfg_data_i = bit_at(1);
        #1;
        check("R7 before edge", 32'(sum_o[0]), 32'h1);
        @(posedge clk);
        #1;
        cfg_we_i = 1'b0;
        check("R7 after edge", 32'(sum_o[0]), 32'h0);
        check("R4 shared term in out6", 32'(sum_o[6]), 32'h0);

        done = 1;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule